// File: doc/BRIEF.md
# Ten-Source Two-Level Interrupt Controller

This block gathers the interrupt requests of a small processor core: two external inputs that can work on level or on edge, three timer overflow requests, the serial port request, and four extra external inputs that only work on edges, each with a fixed polarity. Every source passes through its own enable and through a global enable. A programmable high/low bit per source picks one of two priority levels, and a fixed natural order settles ties inside a level. The winner is offered to the core as a vector address.

The controller tracks nesting with one in-service bit per level. A low-level service can be interrupted by a high-level request but not by another low-level one; during a high-level service nothing is offered. The core takes a vector with a valid/ready handshake: a vector counts as accepted only in a cycle where both `vec_valid` and `vec_ready` are high. Back-pressure is allowed for as long as the core likes, but the offer is not a queued item: while it waits, the offer follows the live requests, so a higher-priority arrival replaces it and a withdrawn request removes it. A return strobe from the core closes the most recent service.

Top module: `irq10_ctrl`

## Requirements
- R1: Source indices are 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 aux0, 7 aux1, 8 aux2, 9 aux3; among eligible requests of the same level the lowest index is offered.
- R2: The vector for index 0 to 5 is 03h plus 8 times the index; for index 6 to 9 it is 43h plus 8 times (index minus 6).
- R3: A high-level eligible request (its bit in `base_hi`/`aux_hi` is 1) is offered ahead of any low-level one, whatever their natural order; `vec_hi` shows the level of the offer.
- R4: `in_service` bit 1 marks a high-level service and bit 0 a low-level one; an accepted vector sets the bit of its level; while bit 1 is set nothing is offered, while only bit 0 is set only high-level requests are offered.
- R5: `irq_return` clears bit 1 of `in_service` when it is set, otherwise bit 0; a return and an accept in the same cycle apply the return first.
- R6: A request is eligible only when its enable bit (`base_en` bit i for i below 6, `aux_en` bit i-6 above) and `glob_en` are both 1; a disabled request keeps its flag.
- R7: aux0 and aux2 flag on a rising pin edge, aux1 and aux3 on a falling edge; the flags appear on `aux_flags` bits 4 to 7 (aux0 to aux3), bits 0 to 3 read 0; a flag stays set until its `aux_clr` strobe, and an edge in the same cycle as the strobe wins.
- R8: `base_flags` bit 0 and bit 2 hold the ext0 and ext1 requests; with the `ext_edge` bit 0 the request follows the active-low pin, with it 1 a falling pin edge sets a sticky flag that is cleared when that vector is accepted (an edge in the same cycle wins).
- R9: Timer0 and timer1 overflow pulses set `base_flags` bits 1 and 3, cleared when their vector is accepted (a pulse in the same cycle wins); the serial request is the OR of `ser_tx_flag` and `ser_rx_flag`, and it and `tmr2_flag` are live inputs that acceptance does not clear.
- R10: External pins pass through two synchronizer stages: a level request is visible after the second clock edge following a pin change, an edge flag after the third.
- R11: `vec_ready` while `vec_valid` is low has no effect on `in_service` or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | Active-low pins of ext0 and ext1 |
| ext_edge | input | 2 | Per ext input: 1 edge mode, 0 level mode |
| tmr_ovf | input | 2 | Overflow pulses of timer0 and timer1 |
| tmr2_flag | input | 1 | Timer2 request flag (cleared at its source) |
| ser_tx_flag | input | 1 | Serial transmit flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| aux_pin | input | 4 | Pins of aux0 to aux3 |
| aux_clr | input | 4 | Clear strobes for the aux flags |
| glob_en | input | 1 | Global enable |
| base_en | input | 6 | Enables for sources 0 to 5 |
| base_hi | input | 6 | Level bits for sources 0 to 5 (1 high) |
| aux_en | input | 4 | Enables for sources 6 to 9 |
| aux_hi | input | 4 | Level bits for sources 6 to 9 (1 high) |
| vec_ready | input | 1 | Core takes the offered vector |
| irq_return | input | 1 | Core leaves the current service |
| vec_valid | output | 1 | A vector is offered |
| vec_addr | output | 8 | Offered vector address |
| vec_hi | output | 1 | Level of the offered vector |
| base_flags | output | 4 | ext0, timer0, ext1, timer1 requests (bits 0 to 3) |
| aux_flags | output | 8 | aux flags in bits 4 to 7 |
| in_service | output | 2 | In-service bits, bit 1 high level |

## Verification
The bench aims at nesting: a low service preempted by a high request, a second low request held back while the first is in service, and two returns unwinding in order; a controller that cleared the wrong in-service bit would reopen low requests too early or lock them out. It checks that a high-level request outranks a naturally higher low-level one and that the lowest index wins within a level, which a reversed scan would break. Automatic clearing is probed where it applies (timer overflows, edge-mode ext inputs) and where it must not (serial, timer2, aux flags, level-mode ext), and the synchronizer delay is sampled on both sides of the cycle a flag appears, so an extra or missing stage shows up as an early or late flag.

// File: rtl/irq10_pkg.sv
`timescale 1ns/1ps
package irq10_pkg;
  localparam int NSRC  = 10;
  localparam int NBASE = 6;
  localparam int NAUX  = NSRC - NBASE;
  localparam int NEXT  = 2;
  localparam int NPIN  = NEXT + NAUX;
  localparam int IDW   = $clog2(NSRC);
  localparam int VW    = 8;

  localparam logic [VW-1:0] VEC_LO_BASE = 8'h03;
  localparam logic [VW-1:0] VEC_HI_BASE = 8'h43;
  localparam logic [VW-1:0] VEC_STEP    = 8'h08;

  // aux inputs that flag on a rising edge; the others flag on a falling edge
  localparam logic [NAUX-1:0] AUX_RISE = 4'b0101;
  // idle level of every pin: ext inputs are active low, aux idle opposite to their edge
  localparam logic [NPIN-1:0] PIN_IDLE = {~AUX_RISE, {NEXT{1'b1}}};
  localparam logic [NPIN-1:0] PIN_RISE = {AUX_RISE, {NEXT{1'b0}}};

  function automatic logic [IDW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDW'(i);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] vec_of(input logic [IDW-1:0] idx);
    if (idx < IDW'(NBASE)) return VEC_LO_BASE + VW'(idx) * VEC_STEP;
    return VEC_HI_BASE + VW'(idx - IDW'(NBASE)) * VEC_STEP;
  endfunction
endpackage

// File: rtl/irq10_sync.sv
`timescale 1ns/1ps
module irq10_sync #(
  parameter int W = 6,
  parameter logic [W-1:0] IDLE = '1,
  parameter logic [W-1:0] RISE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] hit
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl = s2;

  for (genvar i = 0; i < W; i++) begin : g_edge
    if (RISE[i]) begin : g_rise
      assign hit[i] = s2[i] & ~s3[i];
    end else begin : g_fall
      assign hit[i] = ~s2[i] & s3[i];
    end
  end

  // R10: an edge pulse lasts exactly one cycle
  p_hit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((hit & $past(hit)) == '0));
endmodule

// File: rtl/irq10_flags.sv
`timescale 1ns/1ps
module irq10_flags
  import irq10_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_lvl,
  input  logic [NEXT-1:0] ext_hit,
  input  logic [NEXT-1:0] ext_edge,
  input  logic [NEXT-1:0] tmr_ovf,
  input  logic [NAUX-1:0] aux_hit,
  input  logic [NAUX-1:0] aux_clr,
  input  logic            ack,
  input  logic [IDW-1:0]  ack_idx,
  output logic [2*NEXT-1:0] base_req,
  output logic [NAUX-1:0] aux_flag
);
  logic [NEXT-1:0] ext_st;
  logic [NEXT-1:0] tmr_st;

  for (genvar j = 0; j < NEXT; j++) begin : g_pair
    localparam logic [IDW-1:0] EXT_IDX = IDW'(2 * j);
    localparam logic [IDW-1:0] TMR_IDX = IDW'(2 * j + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_st[j] <= 1'b0;
      else if (!ext_edge[j]) ext_st[j] <= 1'b0;
      else if (ext_hit[j]) ext_st[j] <= 1'b1;
      else if (ack && ack_idx == EXT_IDX) ext_st[j] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_st[j] <= 1'b0;
      else if (tmr_ovf[j]) tmr_st[j] <= 1'b1;
      else if (ack && ack_idx == TMR_IDX) tmr_st[j] <= 1'b0;
    end

    assign base_req[2*j]   = ext_edge[j] ? ext_st[j] : ~ext_lvl[j];
    assign base_req[2*j+1] = tmr_st[j];

    // R8: a falling edge in edge mode leaves a pending request
    p_ext_edge_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_edge[j] && ext_hit[j]) |=> (!ext_edge[j] || base_req[2*j]));
    // R9: accepting a timer vector clears its flag
    p_tmr_autoclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_idx == TMR_IDX && !tmr_ovf[j]) |=> !base_req[2*j+1]);
  end

  for (genvar k = 0; k < NAUX; k++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aux_flag[k] <= 1'b0;
      else if (aux_hit[k]) aux_flag[k] <= 1'b1;
      else if (aux_clr[k]) aux_flag[k] <= 1'b0;
    end

    // R7: without an edge or a clear strobe the flag holds
    p_aux_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!aux_hit[k] && !aux_clr[k]) |=> $stable(aux_flag[k]));
  end
endmodule

// File: rtl/irq10_arb.sv
`timescale 1ns/1ps
module irq10_arb
  import irq10_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] hi,
  input  logic            ready,
  input  logic            ret,
  output logic            valid,
  output logic [VW-1:0]   vec,
  output logic            vec_hi,
  output logic [1:0]      in_svc,
  output logic            ack,
  output logic [IDW-1:0]  ack_idx
);
  logic [NSRC-1:0] cand_hi, cand_lo;
  logic [IDW-1:0]  idx_hi, idx_lo;
  logic [1:0]      svc_nxt;

  assign cand_hi = pend &  hi & {NSRC{~in_svc[1]}};
  assign cand_lo = pend & ~hi & {NSRC{in_svc == 2'b00}};
  assign idx_hi  = first_set(cand_hi);
  assign idx_lo  = first_set(cand_lo);

  assign vec_hi  = |cand_hi;
  assign valid   = vec_hi | (|cand_lo);
  assign ack_idx = vec_hi ? idx_hi : idx_lo;
  assign vec     = vec_of(ack_idx);
  assign ack     = valid & ready;

  always_comb begin
    svc_nxt = in_svc;
    if (ret) begin
      if (svc_nxt[1]) svc_nxt[1] = 1'b0;
      else svc_nxt[0] = 1'b0;
    end
    if (ack) svc_nxt[vec_hi] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_svc <= 2'b00;
    else in_svc <= svc_nxt;
  end

  p_hi_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !valid);
  p_lo_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc[0] && valid) |-> vec_hi);
  p_ack_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_hi) |=> in_svc[1]);
  p_ack_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !vec_hi) |=> in_svc[0]);
  p_ret_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && in_svc == 2'b11) |=> (in_svc == 2'b01));
  p_ret_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && in_svc == 2'b01) |=> (in_svc == 2'b00));
endmodule

// File: rtl/irq10_ctrl.sv
`timescale 1ns/1ps
module irq10_ctrl
  import irq10_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_pin_n,
  input  logic [1:0]      ext_edge,
  input  logic [1:0]      tmr_ovf,
  input  logic            tmr2_flag,
  input  logic            ser_tx_flag,
  input  logic            ser_rx_flag,
  input  logic [3:0]      aux_pin,
  input  logic [3:0]      aux_clr,
  input  logic            glob_en,
  input  logic [5:0]      base_en,
  input  logic [5:0]      base_hi,
  input  logic [3:0]      aux_en,
  input  logic [3:0]      aux_hi,
  input  logic            vec_ready,
  input  logic            irq_return,
  output logic            vec_valid,
  output logic [7:0]      vec_addr,
  output logic            vec_hi,
  output logic [3:0]      base_flags,
  output logic [7:0]      aux_flags,
  output logic [1:0]      in_service
);
  logic [NEXT-1:0] ext_lvl;
  logic [NAUX-1:0] aux_lvl_unused;
  logic [NPIN-1:0] pin_hit;
  logic [NAUX-1:0] aux_flag;
  logic [3:0]      base_req;
  logic [NSRC-1:0] req, pend;
  logic            ack;
  logic [IDW-1:0]  ack_idx;

  irq10_sync #(.W(NPIN), .IDLE(PIN_IDLE), .RISE(PIN_RISE)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .pin ({aux_pin, ext_pin_n}),
    .lvl ({aux_lvl_unused, ext_lvl}),
    .hit (pin_hit)
  );

  irq10_flags u_flags (
    .clk (clk),
    .rst_n (rst_n),
    .ext_lvl (ext_lvl),
    .ext_hit (pin_hit[NEXT-1:0]),
    .ext_edge (ext_edge),
    .tmr_ovf (tmr_ovf),
    .aux_hit (pin_hit[NPIN-1:NEXT]),
    .aux_clr (aux_clr),
    .ack (ack),
    .ack_idx (ack_idx),
    .base_req (base_req),
    .aux_flag (aux_flag)
  );

  assign req  = {aux_flag, tmr2_flag, ser_tx_flag | ser_rx_flag, base_req};
  assign pend = req & {aux_en, base_en} & {NSRC{glob_en}};

  irq10_arb u_arb (
    .clk (clk),
    .rst_n (rst_n),
    .pend (pend),
    .hi ({aux_hi, base_hi}),
    .ready (vec_ready),
    .ret (irq_return),
    .valid (vec_valid),
    .vec (vec_addr),
    .vec_hi (vec_hi),
    .in_svc (in_service),
    .ack (ack),
    .ack_idx (ack_idx)
  );

  assign base_flags = base_req;
  assign aux_flags  = {aux_flag, {(8 - NAUX){1'b0}}};

  // R6: nothing is offered while the global enable is low
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !vec_valid);
  // R11: a ready without an offer leaves the nesting state alone
  p_idle_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ready && !vec_valid && !irq_return) |=> $stable(in_service));
endmodule

// File: tb/irq10_ctrl_tb.sv
`timescale 1ns/1ps
module irq10_ctrl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
  logic       tmr2_flag = 0, ser_tx_flag = 0, ser_rx_flag = 0;
  logic [3:0] aux_pin = 4'b1010, aux_clr = 4'b0000;
  logic       glob_en = 0;
  logic [5:0] base_en = 0, base_hi = 0;
  logic [3:0] aux_en = 0, aux_hi = 0;
  logic       vec_ready = 0, irq_return = 0;
  logic       vec_valid, vec_hi;
  logic [7:0] vec_addr, aux_flags;
  logic [3:0] base_flags;
  logic [1:0] in_service;

  irq10_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .tmr2_flag(tmr2_flag), .ser_tx_flag(ser_tx_flag),
    .ser_rx_flag(ser_rx_flag), .aux_pin(aux_pin), .aux_clr(aux_clr),
    .glob_en(glob_en), .base_en(base_en), .base_hi(base_hi), .aux_en(aux_en),
    .aux_hi(aux_hi), .vec_ready(vec_ready), .irq_return(irq_return),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_hi(vec_hi),
    .base_flags(base_flags), .aux_flags(aux_flags), .in_service(in_service)
  );

  int total = 0, bad = 0;
  bit running = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state: pin history, sticky flags, nesting bits
  logic [5:0] p1 = 6'b101011, p2 = 6'b101011, p3 = 6'b101011;
  logic [1:0] m_est = 0, m_tf = 0, m_isv = 0;
  logic [3:0] m_af = 0;

  function automatic int exp_vec(input int i);
    case (i)
      0: return 'h03; 1: return 'h0B; 2: return 'h13; 3: return 'h1B; 4: return 'h23;
      5: return 'h2B; 6: return 'h43; 7: return 'h4B; 8: return 'h53; default: return 'h5B;
    endcase
  endfunction

  function automatic logic [3:0] m_base();
    logic [3:0] b;
    b[0] = ext_edge[0] ? m_est[0] : !p2[0];
    b[1] = m_tf[0];
    b[2] = ext_edge[1] ? m_est[1] : !p2[1];
    b[3] = m_tf[1];
    return b;
  endfunction

  task automatic predict(output bit v, output int idx, output bit h);
    logic [9:0] r, en, hp;
    r = {m_af, tmr2_flag, ser_tx_flag | ser_rx_flag, m_base()};
    en = {aux_en, base_en};
    hp = {aux_hi, base_hi};
    v = 0; idx = 0; h = 0;
    if (glob_en) begin
      if (!m_isv[1])
        for (int i = 0; i < 10; i++)
          if (!v && r[i] && en[i] && hp[i]) begin v = 1; idx = i; h = 1; end
      if (!v && m_isv == 2'b00)
        for (int i = 0; i < 10; i++)
          if (!v && r[i] && en[i] && !hp[i]) begin v = 1; idx = i; end
    end
  endtask

  always @(posedge clk) begin
    bit v, h, acc, e;
    int idx;
    if (!rst_n) begin
      p1 = 6'b101011; p2 = 6'b101011; p3 = 6'b101011;
      m_est = 0; m_tf = 0; m_isv = 0; m_af = 0;
    end else begin
      predict(v, idx, h);
      acc = v && vec_ready;
      for (int j = 0; j < 2; j++) begin
        if (!ext_edge[j]) m_est[j] = 0;
        else if (p3[j] && !p2[j]) m_est[j] = 1;
        else if (acc && idx == 2 * j) m_est[j] = 0;
        if (tmr_ovf[j]) m_tf[j] = 1;
        else if (acc && idx == 2 * j + 1) m_tf[j] = 0;
      end
      for (int k = 0; k < 4; k++) begin
        e = (k % 2 == 0) ? (p2[k+2] && !p3[k+2]) : (!p2[k+2] && p3[k+2]);
        if (e) m_af[k] = 1;
        else if (aux_clr[k]) m_af[k] = 0;
      end
      if (irq_return) begin
        if (m_isv[1]) m_isv[1] = 0; else m_isv[0] = 0;
      end
      if (acc) m_isv[h] = 1;
      p3 = p2; p2 = p1; p1 = {aux_pin, ext_pin_n};
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    bit v, h;
    int idx;
    if (running) begin
      #1;
      predict(v, idx, h);
      chk("R1/R6 offer valid", vec_valid, v);
      if (v) begin
        chk("R1/R2 vector", vec_addr, exp_vec(idx));
        chk("R3 offer level", vec_hi, h);
      end
      chk("R8/R9 base flags", base_flags, m_base());
      chk("R7 aux flags", aux_flags, {m_af, 4'b0000});
      chk("R4/R5 in-service", in_service, m_isv);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept();
    vec_ready = 1; tick; vec_ready = 0;
  endtask

  task automatic leave();
    irq_return = 1; tick; irq_return = 0;
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1;
    running = 1;
    tick; #2;
    chk("R4 reset in-service", in_service, 0);
    chk("R6 reset no offer", vec_valid, 0);
    chk("R7 reset aux flags", aux_flags, 0);
    chk("R8 reset base flags", base_flags, 0);

    // R11: ready with no offer
    glob_en = 1; base_en = 6'b011000; vec_ready = 1; tick; vec_ready = 0; #2;
    chk("R11 idle ready", in_service, 0);

    // R1 / R2 / R9: timer1 ahead of serial at the same level
    tmr_ovf[1] = 1; ser_rx_flag = 1; tick; tmr_ovf = 0; #2;
    chk("R1 timer1 before serial", vec_addr, 8'h1B);
    accept(); #2;
    chk("R4 low busy", in_service, 2'b01);
    chk("R4 low blocked", vec_valid, 0);
    chk("R9 timer1 autoclear", base_flags[3], 0);
    leave(); #2;
    chk("R5 return low", in_service, 0);
    chk("R9 serial kept", vec_addr, 8'h23);
    ser_rx_flag = 0; ser_tx_flag = 1; tick; #2;
    chk("R9 serial tx", vec_addr, 8'h23);
    ser_tx_flag = 0;

    // R3 / R10: aux1 falling edge, high level, against low timer0
    base_en = 6'b000010; aux_en = 4'b0011; aux_hi = 4'b0011;
    tmr_ovf[0] = 1; aux_pin = 4'b1000; tick; tmr_ovf = 0; #2;
    chk("R10 first edge", aux_flags, 0);
    chk("R1 timer0 offer", vec_addr, 8'h0B);
    tick; #2;
    chk("R10 second edge", aux_flags, 0);
    tick; #2;
    chk("R10 third edge", aux_flags, 8'h20);
    chk("R3 high wins", vec_addr, 8'h4B);
    chk("R3 high flag", vec_hi, 1);
    accept(); #2;
    chk("R4 high busy", in_service, 2'b10);
    chk("R4 high blocks all", vec_valid, 0);
    leave(); #2;
    chk("R7 aux sticky after accept", aux_flags, 8'h20);
    aux_clr = 4'b0010; aux_pin = 4'b1010; tick; aux_clr = 0; #2;
    chk("R7 aux clear", aux_flags, 0);
    chk("R1 timer0 back", vec_addr, 8'h0B);
    accept(); #2;
    chk("R9 timer0 autoclear", base_flags[1], 0);
    aux_pin = 4'b1011; tick(3); #2;
    chk("R4 preempt low", vec_addr, 8'h43);
    accept(); #2;
    chk("R4 nested", in_service, 2'b11);
    leave(); #2;
    chk("R5 return high first", in_service, 2'b01);
    leave(); #2;
    chk("R5 return low", in_service, 2'b00);
    aux_clr = 4'b0001; aux_pin = 4'b1010; tick; aux_clr = 0;

    // R8 / R6: ext0 edge mode under global disable
    glob_en = 0; base_en = 6'b000101; aux_en = 0; ext_edge = 2'b01;
    ext_pin_n[0] = 0; tick; ext_pin_n[0] = 1; tick(4); #2;
    chk("R8 edge flag", base_flags[0], 1);
    chk("R6 global off", vec_valid, 0);
    glob_en = 1; tick; #2;
    chk("R6 global on", vec_addr, 8'h03);
    accept(); #2;
    chk("R8 edge autoclear", base_flags[0], 0);
    leave();
    ext_pin_n[1] = 0; tick; #2;
    chk("R10 level early", base_flags[2], 0);
    tick; #2;
    chk("R8 level request", base_flags[2], 1);
    chk("R2 ext1 vector", vec_addr, 8'h13);
    accept(); #2;
    chk("R8 level not cleared", base_flags[2], 1);
    ext_pin_n[1] = 1; leave(); tick(3);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      ext_pin_n   = 2'($urandom_range(0, 3));
      aux_pin     = 4'($urandom);
      tmr_ovf     = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      tmr2_flag   = ($urandom_range(0, 3) == 0);
      ser_tx_flag = ($urandom_range(0, 5) == 0);
      ser_rx_flag = ($urandom_range(0, 5) == 0);
      aux_clr     = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0000;
      vec_ready   = ($urandom_range(0, 2) == 0);
      irq_return  = ($urandom_range(0, 4) == 0);
      if (n % 64 == 0) begin
        glob_en  = ($urandom_range(0, 7) != 0);
        base_en  = 6'($urandom); base_hi = 6'($urandom);
        aux_en   = 4'($urandom); aux_hi  = 4'($urandom);
        ext_edge = 2'($urandom);
      end
      tick;
    end
    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule